// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the clock waveform of an I2C master. Each speed mode has its own pair of programmable counts, one for the high phase and one for the low phase. A two-bit speed field picks the pair in use. The block also removes short glitches from the sampled SCL and SDA lines. It delays every SDA change by a programmable number of core clocks after SCL is pulled low, and it gives a byte sequencer one strobe for sampling a data bit and one for driving a data bit.

A sequencer outside the block sets the controller enable and holds a bus request while it wants clock periods. The block then runs low and high phases back to back. The low phase is a fixed count. The high phase is counted only once the filtered SCL line reads high, so a slave that holds SCL low stretches the clock. Configuration is written through a simple write port, which takes writes only while the controller is disabled.

Top module: `scl_timing_gen`

## Requirements
- R1: During and after reset, `scl_oe` and `sda_oe` are 0, both strobes are 0, and both filtered outputs read 1. The write-port registers start at their reset parameter values.
- R2: Each low phase asserts `scl_oe` for exactly LCNT+1 consecutive core clock cycles, where LCNT is the low count of the selected pair.
- R3: Once released, `scl_oe` stays 0 for W + HCNT + SPK + 3 cycles. W is the number of cycles until the filtered SCL is first seen high, plus one. SPK is the active spike length.
- R4: Register map at `wr_addr`: 0 speed field (bits 1:0); 1/2 standard high/low; 3/4 fast high/low; 5/6 high-speed high/low; 7 spike length for standard and fast; 8 spike length for high speed; 9 SDA hold count. Speed codes 00 and 01 select the standard pair, 10 the fast pair and 11 the high-speed pair.
- R5: The active spike length is register 7 in standard and fast modes and register 8 in high-speed mode. It is used both by the filters and in the high-phase length.
- R6: A filtered output takes a new input value only after the raw input has held that value for max(SPK,1) consecutive samples. A shorter pulse leaves the output unchanged.
- R7: A write while `ctl_en` is 1 has no effect on any register.
- R8: A slave that holds SCL low after release extends the released time by exactly the number of cycles it holds the line.
- R9: `sample_stb` pulses once per high phase, in high-phase cycle floor((HCNT+SPK+3)/2), counted from 0 at the first counted cycle.
- R10: `drive_stb` pulses once per low phase, in low-phase cycle min(HOLD, LCNT). In the next cycle `sda_oe` equals the inverse of `sda_bit` sampled with the strobe.
- R11: With `bus_req` low at the end of a high phase the block goes idle and keeps `scl_oe` at 0. With `ctl_en` low the block is idle from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Controller enable; also locks the configuration |
| bus_req | input | 1 | Sequencer wants further clock periods |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| scl_in | input | 1 | Raw sampled SCL line |
| sda_in | input | 1 | Raw sampled SDA line |
| sda_bit | input | 1 | Next data bit to place on SDA |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| scl_filt | output | 1 | Spike-filtered SCL |
| sda_filt | output | 1 | Spike-filtered SDA |
| sample_stb | output | 1 | Sample the data bit now |
| drive_stb | output | 1 | Data bit may change now |

## Verification
The hardest case to reach is the interaction of clock stretching with the filter latency. The released time depends on how long a slave holds SCL and on the spike length, and these add together in the wait count before the high phase starts. The bench closes the loop by driving SCL from `scl_oe` and adds a stretch of random length at the moment of release. Random speed modes, counts, spike lengths and hold values are used, including holds longer than the low count, so the clamp on the drive strobe is exercised.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;
    parameter int unsigned CNT_W   = 16;
    parameter int unsigned SPK_W   = 8;
    parameter int unsigned ADDR_W  = 4;
    parameter int unsigned DATA_W  = 16;
    parameter int unsigned N_MODES = 3;
    localparam int unsigned PH_W     = CNT_W + 2;
    localparam int unsigned HI_FIXED = 3;

    localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
    localparam logic [ADDR_W-1:0] A_SPK_NORM = 4'd7;
    localparam logic [ADDR_W-1:0] A_SPK_HS   = 4'd8;
    localparam logic [ADDR_W-1:0] A_HOLD     = 4'd9;

    typedef enum logic [1:0] {
        SPD_DEF  = 2'b00,
        SPD_STD  = 2'b01,
        SPD_FAST = 2'b10,
        SPD_HIGH = 2'b11
    } speed_e;

    typedef enum logic [1:0] {
        PH_IDLE, PH_LOW, PH_WAIT_HI, PH_HIGH
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] hcnt;
        logic [CNT_W-1:0] lcnt;
        logic [SPK_W-1:0] spk;
        logic [CNT_W-1:0] hold;
    } timing_cfg_t;

    function automatic int unsigned mode_index(speed_e s);
        case (s)
            SPD_HIGH: return 2;
            SPD_FAST: return 1;
            default:  return 0;
        endcase
    endfunction

    function automatic logic [PH_W-1:0] high_len(logic [CNT_W-1:0] h, logic [SPK_W-1:0] s);
        return PH_W'(h) + PH_W'(s) + PH_W'(HI_FIXED);
    endfunction

    function automatic logic [CNT_W-1:0] hold_point(logic [CNT_W-1:0] hold, logic [CNT_W-1:0] lcnt);
        return (hold > lcnt) ? lcnt : hold;
    endfunction
endpackage

// File: rtl/scl_tg_filter.sv
module scl_tg_filter
    import scl_tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             raw,
    input  logic [SPK_W-1:0] len,
    output logic             filt
);
    logic [SPK_W-1:0] run_q;
    logic [SPK_W:0]   need;
    logic             filt_q;

    assign need = (len == '0) ? (SPK_W+1)'(1) : {1'b0, len};
    assign filt = filt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_q <= 1'b1;
            run_q  <= '0;
        end else if (raw == filt_q) begin
            run_q <= '0;
        end else if (({1'b0, run_q} + 1'b1) >= need) begin
            filt_q <= raw;
            run_q  <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // R6: the output only ever moves to the value the input carried at that edge
    assert_filt_follow_R6: assert property (@(posedge clk) disable iff (rst)
        (filt_q != $past(filt_q)) |-> (filt_q == $past(raw)));
endmodule

// File: rtl/scl_tg_regs.sv
module scl_tg_regs
    import scl_tg_pkg::*;
#(
    parameter logic [CNT_W-1:0] RST_HCNT = 16'd40,
    parameter logic [CNT_W-1:0] RST_LCNT = 16'd47,
    parameter logic [SPK_W-1:0] RST_SPK  = 8'd1,
    parameter logic [CNT_W-1:0] RST_HOLD = 16'd2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output timing_cfg_t       cfg
);
    logic             wr_ok;
    speed_e           speed_q;
    logic [SPK_W-1:0] spk_norm_q, spk_hs_q;
    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] hi_q [N_MODES];
    logic [CNT_W-1:0] lo_q [N_MODES];
    int unsigned      sel;

    assign wr_ok = wr_en && !ctl_en;

    for (genvar m = 0; m < N_MODES; m++) begin : g_pair
        localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(1 + 2*m);
        localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(2 + 2*m);
        always_ff @(posedge clk) begin
            if (rst) begin
                hi_q[m] <= RST_HCNT;
                lo_q[m] <= RST_LCNT;
            end else if (wr_ok) begin
                if (wr_addr == HI_A) hi_q[m] <= wr_data[CNT_W-1:0];
                if (wr_addr == LO_A) lo_q[m] <= wr_data[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            speed_q    <= SPD_STD;
            spk_norm_q <= RST_SPK;
            spk_hs_q   <= RST_SPK;
            hold_q     <= RST_HOLD;
        end else if (wr_ok) begin
            case (wr_addr)
                A_CTRL:     speed_q    <= speed_e'(wr_data[1:0]);
                A_SPK_NORM: spk_norm_q <= wr_data[SPK_W-1:0];
                A_SPK_HS:   spk_hs_q   <= wr_data[SPK_W-1:0];
                A_HOLD:     hold_q     <= wr_data[CNT_W-1:0];
                default:    ;
            endcase
        end
    end

    always_comb begin
        sel      = mode_index(speed_q);
        cfg.hcnt = hi_q[sel];
        cfg.lcnt = lo_q[sel];
        cfg.spk  = (sel == 2) ? spk_hs_q : spk_norm_q;
        cfg.hold = hold_q;
    end

    // R7: configuration seen by the phase logic is frozen while enabled
    assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (ctl_en && $past(ctl_en)) |-> $stable(cfg));
endmodule

// File: rtl/scl_tg_phase.sv
module scl_tg_phase
    import scl_tg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_en,
    input  logic        bus_req,
    input  logic        scl_filt,
    input  logic        sda_bit,
    input  timing_cfg_t cfg,
    output logic        scl_oe,
    output logic        sda_oe,
    output logic        sample_stb,
    output logic        drive_stb
);
    phase_e          state_q;
    logic [PH_W-1:0] cnt_q;
    logic [PH_W-1:0] hi_total;
    logic [PH_W-1:0] drive_at;
    logic            sda_oe_q;

    assign hi_total   = high_len(cfg.hcnt, cfg.spk);
    assign drive_at   = PH_W'(hold_point(cfg.hold, cfg.lcnt));
    assign scl_oe     = (state_q == PH_LOW);
    assign sample_stb = (state_q == PH_HIGH) && (cnt_q == (hi_total >> 1));
    assign drive_stb  = (state_q == PH_LOW) && (cnt_q == drive_at);
    assign sda_oe     = sda_oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PH_IDLE;
            cnt_q    <= '0;
            sda_oe_q <= 1'b0;
        end else begin
            case (state_q)
                PH_IDLE: begin
                    cnt_q <= '0;
                    if (bus_req) state_q <= PH_LOW;
                end
                PH_LOW: begin
                    if (cnt_q == PH_W'(cfg.lcnt)) begin
                        state_q <= PH_WAIT_HI;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_WAIT_HI: begin
                    cnt_q <= '0;
                    if (scl_filt) state_q <= PH_HIGH;
                end
                default: begin
                    if (cnt_q == hi_total - 1'b1) begin
                        state_q <= bus_req ? PH_LOW : PH_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
            if (!ctl_en) begin
                state_q <= PH_IDLE;
                cnt_q   <= '0;
            end
            if (drive_stb) sda_oe_q <= ~sda_bit;
        end
    end

    // R2: the low counter never passes the programmed low count
    assert_low_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_LOW) |-> (cnt_q <= PH_W'(cfg.lcnt)));
    // R8: high counting begins only after the filter reported SCL high
    assert_wait_filt_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_HIGH && $past(state_q) == PH_WAIT_HI) |-> $past(scl_filt));
    // R10: the data line follows the bit taken with the drive strobe
    assert_sda_update_R10: assert property (@(posedge clk) disable iff (rst)
        $past(drive_stb) |-> (sda_oe == !$past(sda_bit)));
    // R9 / R10: the two strobes never coincide
    assert_stb_excl_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sample_stb, drive_stb}));
    // R11: disabling releases SCL on the next cycle
    assert_disable_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(ctl_en) |-> !scl_oe);
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_tg_pkg::*;
#(
    parameter logic [CNT_W-1:0] RST_HCNT = 16'd40,
    parameter logic [CNT_W-1:0] RST_LCNT = 16'd47,
    parameter logic [SPK_W-1:0] RST_SPK  = 8'd1,
    parameter logic [CNT_W-1:0] RST_HOLD = 16'd2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_en,
    input  logic        bus_req,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [15:0] wr_data,
    input  logic        scl_in,
    input  logic        sda_in,
    input  logic        sda_bit,
    output logic        scl_oe,
    output logic        sda_oe,
    output logic        scl_filt,
    output logic        sda_filt,
    output logic        sample_stb,
    output logic        drive_stb
);
    localparam int unsigned N_LINES = 2;

    timing_cfg_t        cfg;
    logic [N_LINES-1:0] raw_vec;
    logic [N_LINES-1:0] filt_vec;

    assign raw_vec  = {sda_in, scl_in};
    assign scl_filt = filt_vec[0];
    assign sda_filt = filt_vec[1];

    scl_tg_regs #(
        .RST_HCNT(RST_HCNT), .RST_LCNT(RST_LCNT),
        .RST_SPK(RST_SPK),   .RST_HOLD(RST_HOLD)
    ) u_regs (
        .clk(clk), .rst(rst), .ctl_en(ctl_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .cfg(cfg)
    );

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        scl_tg_filter u_filt (
            .clk(clk), .rst(rst), .raw(raw_vec[i]),
            .len(cfg.spk), .filt(filt_vec[i])
        );
    end

    scl_tg_phase u_phase (
        .clk(clk), .rst(rst), .ctl_en(ctl_en), .bus_req(bus_req),
        .scl_filt(filt_vec[0]), .sda_bit(sda_bit), .cfg(cfg),
        .scl_oe(scl_oe), .sda_oe(sda_oe),
        .sample_stb(sample_stb), .drive_stb(drive_stb)
    );
endmodule

// File: tb/scl_timing_gen_bench.sv
module scl_timing_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_en = 1'b0, bus_req = 1'b0, wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        sda_in = 1'b1, sda_bit = 1'b0, stretch = 1'b0;
    logic        scl_in;
    logic        scl_oe, sda_oe, scl_filt, sda_filt, sample_stb, drive_stb;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;
    assign scl_in = ~(scl_oe | stretch);

    scl_timing_gen u_scl_timing_gen (
        .clk(clk), .rst(rst), .ctl_en(ctl_en), .bus_req(bus_req),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .scl_in(scl_in), .sda_in(sda_in), .sda_bit(sda_bit),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_filt(scl_filt),
        .sda_filt(sda_filt), .sample_stb(sample_stb), .drive_stb(drive_stb)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_spk(int s);
        return (s == 0) ? 1 : s;
    endfunction
    function automatic int exp_released(int h, int s, int st);
        return st + eff_spk(s) + 1 + h + s + 3;
    endfunction
    function automatic int exp_sample(int h, int s, int st);
        return st + eff_spk(s) + 1 + (h + s + 3) / 2;
    endfunction
    function automatic int exp_drive(int hold, int l);
        return (hold > l) ? l : hold;
    endfunction

    task automatic wr(input int a, input int d);
        wr_addr = 4'(a); wr_data = 16'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic sync_low();
        while (scl_oe) @(negedge clk);
        while (!scl_oe) @(negedge clk);
    endtask

    // entered at the first low cycle of a period; returns at the next one
    task automatic run_one(input int l, input int h, input int s, input int hold,
                           input int st, input bit sbit, input string tag);
        int lowlen = 0, dpos = -1, rel = 0, spos = -1, nstb = 0;
        sda_bit = sbit;
        while (scl_oe) begin
            if (drive_stb) begin dpos = lowlen; nstb++; end
            lowlen++;
            @(negedge clk);
        end
        check(lowlen == l + 1, {"R2 low ", tag}, lowlen, l + 1);
        check(dpos == exp_drive(hold, l), {"R10 drive pos ", tag}, dpos, exp_drive(hold, l));
        check(nstb == 1, {"R10 drive count ", tag}, nstb, 1);
        check(sda_oe == !sbit, {"R10 sda ", tag}, int'(sda_oe), int'(!sbit));
        nstb = 0;
        while (!scl_oe) begin
            if (rel == 0 && st > 0) stretch = 1'b1;
            if (rel == st) stretch = 1'b0;
            if (sample_stb) begin spos = rel; nstb++; end
            rel++;
            @(negedge clk);
        end
        stretch = 1'b0;
        check(rel == exp_released(h, s, st), {"R3 R8 released ", tag}, rel, exp_released(h, s, st));
        check(spos == exp_sample(h, s, st), {"R9 sample pos ", tag}, spos, exp_sample(h, s, st));
        check(nstb == 1, {"R9 sample count ", tag}, nstb, 1);
    endtask

    // full configuration with distinct decoys in the unselected pairs
    task automatic configure(input int mode, input int hs[3], input int ls[3],
                             input int spn, input int sph, input int hold);
        ctl_en = 1'b0; bus_req = 1'b0;
        repeat (20) @(negedge clk);
        for (int m = 0; m < 3; m++) begin
            wr(1 + 2*m, hs[m]);
            wr(2 + 2*m, ls[m]);
        end
        wr(7, spn); wr(8, sph); wr(9, hold); wr(0, mode);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int hs[3], ls[3];
        int mode, idx, spn, sph, s, hold, st;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!scl_oe && !sda_oe, "R1 oe", int'(scl_oe | sda_oe), 0);
        check(!sample_stb && !drive_stb, "R1 strobes", int'(sample_stb | drive_stb), 0);
        check(scl_filt && sda_filt, "R1 filt", int'(scl_filt & sda_filt), 1);

        // R1 reset register values: standard pair 40/47, spk 1, hold 2
        ctl_en = 1'b1; bus_req = 1'b1;
        sync_low();
        run_one(47, 40, 1, 2, 0, 1'b1, "reset cfg");

        // R6 glitch filter on SDA with spike length 4
        hs = '{5, 6, 7}; ls = '{12, 13, 14};
        configure(1, hs, ls, 4, 2, 3);
        sda_in = 1'b0;
        repeat (3) @(negedge clk);
        sda_in = 1'b1;
        repeat (6) @(negedge clk);
        check(sda_filt == 1'b1, "R6 short pulse", int'(sda_filt), 1);
        sda_in = 1'b0;
        repeat (3) @(negedge clk);
        check(sda_filt == 1'b1, "R6 before len", int'(sda_filt), 1);
        @(negedge clk);
        check(sda_filt == 1'b0, "R6 after len", int'(sda_filt), 0);
        sda_in = 1'b1;
        repeat (6) @(negedge clk);

        // R7 writes while enabled are ignored (standard L=12 H=5 spk=4)
        ctl_en = 1'b1; bus_req = 1'b1;
        sync_low();
        run_one(12, 5, 4, 3, 0, 1'b0, "pre-write");
        wr(2, 30); wr(0, 3); wr(7, 0);
        sync_low();
        run_one(12, 5, 4, 3, 0, 1'b1, "R7 locked");

        // R11 bus_req low ends clocking after the current period
        bus_req = 1'b0;
        while (scl_oe) @(negedge clk);
        begin
            int lows = 0;
            repeat (300) begin
                if (scl_oe) lows++;
                @(negedge clk);
            end
            check(lows == 0, "R11 idle after request", lows, 0);
        end

        // R11 disabling mid-period releases SCL next cycle
        bus_req = 1'b1;
        sync_low();
        @(negedge clk);
        ctl_en = 1'b0;
        @(negedge clk);
        check(scl_oe == 1'b0, "R11 disable", int'(scl_oe), 0);

        // R4 R5 random modes, counts, stretch and hold clamp
        for (int it = 0; it < 10; it++) begin
            mode = int'($urandom_range(0, 3));
            idx  = (mode == 3) ? 2 : (mode == 2) ? 1 : 0;
            spn  = int'($urandom_range(0, 6));
            sph  = int'($urandom_range(0, 6));
            s    = (idx == 2) ? sph : spn;
            for (int m = 0; m < 3; m++) begin
                hs[m] = int'($urandom_range(0, 20));
                ls[m] = 8 + int'($urandom_range(0, 20));
            end
            hold = int'($urandom_range(0, 30));
            configure(mode, hs, ls, spn, sph, hold);
            ctl_en = 1'b1; bus_req = 1'b1;
            sync_low();
            for (int p = 0; p < 3; p++) begin
                st = (p == 1) ? int'($urandom_range(1, 6)) : 0;
                run_one(ls[idx], hs[idx], s, hold, st, 1'($urandom_range(0, 1)),
                        $sformatf("R4 R5 mode%0d it%0d p%0d", mode, it, p));
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule